// File: doc/BRIEF.md
# Snooping MSI Line Coherence Controller

This block keeps one cache coherent with its peers on a shared snooping bus. The cache is write-back and write-invalidate. The block holds a direct-mapped array of tags, one per line. Each line carries one of three states: Invalid (`LINE_I`), Shared (`LINE_S`, clean and readable, memory up to date) or Exclusive (`LINE_E`, the only copy, writable and dirty). There is no clean-exclusive state. A processor write to a Shared line therefore goes out on the bus as a full write miss, never as a lighter upgrade.

The processor side is a three-state machine:

- `C_IDLE` looks up the request.
- `C_WRBACK` asks memory to take a dirty victim.
- `C_BUSREQ` holds a read-miss or write-miss request until the bus grants it.

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→IDLE | hit |
| IDLE→WRBACK | miss with a dirty victim of another tag |
| IDLE→BUSREQ | miss with a clean or empty victim |
| WRBACK→BUSREQ | `wb_ack` |
| BUSREQ→IDLE | `bus_grant`, after which the line is refilled |

The snoop side watches every bus transaction. It downgrades or invalidates the matching line. When the line was dirty, it raises a supply response.

Snoop traffic has priority over the processor. In any cycle with `snoop_valid` high, the processor machine holds its state and ignores grant and acknowledge. Line addresses are used throughout, so the low `log2(NUM_LINES)` bits are the index and the rest is the tag. Bus operation codes on `bus_req_op` and `snoop_op` are: 0 none, 1 read miss, 2 write miss, 3 invalidate.

Top module: `msi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and `bus_req_valid`, `wb_req_valid`, `supply_valid` and `cpu_done` are low.
- R2: A processor read that misses raises `bus_req_valid` with `bus_req_op`=1 and the request address in the cycle after acceptance. The cycle after `bus_grant`, `cpu_done` pulses with `cpu_hit`=0 and the line holds that tag in Shared.
- R3: A read that hits a Shared or Exclusive line, or a write that hits an Exclusive line, pulses `cpu_done` with `cpu_hit`=1 in the cycle after acceptance. It raises no bus or write-back request.
- R4: A processor write to a line that is Invalid, Shared, or holds another tag raises `bus_req_op`=2 (write miss). After the grant, the line is Exclusive.
- R5: A miss whose victim is Exclusive with a different tag first raises `wb_req_valid` with the victim's address, and no bus request. Only after `wb_ack` does it raise the bus request. The victim line is then Invalid.
- R6: A snooped read miss (op 1) that hits an Exclusive line pulses `supply_valid` the next cycle with `supply_addr` equal to the snooped address. The line becomes Shared.
- R7: A snooped write miss (op 2) or invalidate (op 3) that hits a Shared or Exclusive line makes it Invalid. A supply response is raised only if the line was Exclusive.
- R8: A snoop whose tag differs from the stored tag, or whose line is Invalid, changes no state and raises no supply response.
- R9: While `snoop_valid` is high, `cpu_ready` is low and the processor machine holds its state. A `bus_grant` or `wb_ack` in that cycle has no effect, and `cpu_done` stays low the next cycle.
- R10: Once raised, `bus_req_valid` (with its op and address) and `wb_req_valid` (with its address) stay steady until granted or acknowledged. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_ready | output | 1 | Request accepted this cycle if valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completion needed no bus transaction |
| bus_req_valid | output | 1 | Miss request to the bus |
| bus_req_op | output | 2 | 1 read miss, 2 write miss |
| bus_req_addr | output | ADDR_W | Miss address |
| bus_grant | input | 1 | Bus transaction done, refill data present |
| wb_req_valid | output | 1 | Dirty victim write-back request |
| wb_req_addr | output | ADDR_W | Victim address |
| wb_ack | input | 1 | Memory took the victim |
| snoop_valid | input | 1 | Snooped bus transaction present |
| snoop_op | input | 2 | Snooped operation code |
| snoop_addr | input | ADDR_W | Snooped line address |
| supply_valid | output | 1 | This cache supplies dirty data |
| supply_addr | output | ADDR_W | Address being supplied |

## Verification
Some properties are checked by assertions on every cycle:

- Request holding (R10): a pending miss or write-back request never changes until it is granted or acknowledged.
- Ordering (R5): a write-back is finished before its refill is requested.
- Priority (R9): a snoop cycle never produces a completion.
- Port exclusivity: the snoop path and the processor path never write the array in the same cycle.
- Supply timing: a supply pulse always follows a snoop.
- Local hits: a hit completion coincides with no outstanding request.

Other behaviour is visible only through the directed scenarios. These are the state each line ends up in, which is inferred from whether a later access hits or which bus op it issues (R2, R4, R6–R8). The same applies to the eviction sequence with its exact addresses, and to grant or acknowledge being dropped during a snoop.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LINE_I = 2'd0,
        LINE_S = 2'd1,
        LINE_E = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_RDMISS = 2'd1,
        OP_WRMISS = 2'd2,
        OP_INVAL  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        C_IDLE   = 2'd0,
        C_WRBACK = 2'd1,
        C_BUSREQ = 2'd2
    } cpu_fsm_e;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_idx,
    output logic [TAG_W-1:0]  cpu_tag_o,
    output line_state_e       cpu_state_o,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic [TAG_W-1:0]  snp_tag_o,
    output line_state_e       snp_state_o,
    input  logic              snp_we,
    input  line_state_e       snp_state_i,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_wr_idx,
    input  logic [TAG_W-1:0]  cpu_wr_tag,
    input  line_state_e       cpu_wr_state
);

    logic [TAG_W-1:0] tag_q   [NUM_LINES];
    line_state_e      state_q [NUM_LINES];

    assign cpu_tag_o   = tag_q[cpu_idx];
    assign cpu_state_o = state_q[cpu_idx];
    assign snp_tag_o   = tag_q[snp_idx];
    assign snp_state_o = state_q[snp_idx];

    // Snoop writes win over processor writes on the same line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!rst_n) begin
                state_q[i] <= LINE_I;
                tag_q[i]   <= '0;
            end else if (snp_we && (snp_idx == IDX_W'(i))) begin
                state_q[i] <= snp_state_i;
            end else if (cpu_we && (cpu_wr_idx == IDX_W'(i))) begin
                state_q[i] <= cpu_wr_state;
                tag_q[i]   <= cpu_wr_tag;
            end
        end
    end

    // R9: the processor machine stalls on snoop cycles, so the two writers never collide
    a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_we && cpu_we));

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_valid,
    input  bus_op_e           snoop_op,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_state_e       line_state,
    output logic              wr_en,
    output line_state_e       wr_state,
    output logic              supply_valid,
    output logic [ADDR_W-1:0] supply_addr
);

    logic match;
    logic supply_d;

    assign match = snoop_valid && (line_state != LINE_I)
                   && (line_tag == snoop_addr[ADDR_W-1:ADDR_W-TAG_W]);

    always_comb begin
        wr_en    = 1'b0;
        wr_state = line_state;
        supply_d = 1'b0;
        unique case (snoop_op)
            OP_RDMISS: begin
                if (match && line_state == LINE_E) begin
                    wr_en    = 1'b1;
                    wr_state = LINE_S;
                    supply_d = 1'b1;
                end
            end
            OP_WRMISS, OP_INVAL: begin
                if (match) begin
                    wr_en    = 1'b1;
                    wr_state = LINE_I;
                    supply_d = (line_state == LINE_E);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            supply_valid <= 1'b0;
            supply_addr  <= '0;
        end else begin
            supply_valid <= supply_d;
            supply_addr  <= snoop_addr;
        end
    end

    // R6: a supply response only ever follows a snooped transaction
    a_r6_supply_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        supply_valid |-> $past(snoop_valid));

endmodule

// File: rtl/msi_cpu_fsm.sv
module msi_cpu_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TAG_W  = 8,
    localparam int IDX_W = ADDR_W - TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_valid,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [TAG_W-1:0]  look_tag,
    input  line_state_e       look_state,
    input  logic              bus_grant,
    input  logic              wb_ack,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              bus_req_valid,
    output bus_op_e           bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic              wb_req_valid,
    output logic [ADDR_W-1:0] wb_req_addr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output line_state_e       wr_state
);

    cpu_fsm_e          state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [TAG_W-1:0]  victim_q;

    logic [TAG_W-1:0] req_tag;
    logic             accept, tag_eq, hit, victim_dirty;
    logic             wb_done, bus_done;

    assign req_tag      = cpu_req_addr[ADDR_W-1:IDX_W];
    assign tag_eq       = (look_tag == req_tag);
    assign hit          = tag_eq && (cpu_req_write ? (look_state == LINE_E)
                                                   : (look_state != LINE_I));
    assign victim_dirty = (look_state == LINE_E) && !tag_eq;
    assign accept       = cpu_req_valid && cpu_ready;
    assign wb_done      = (state_q == C_WRBACK) && wb_ack && !snoop_valid;
    assign bus_done     = (state_q == C_BUSREQ) && bus_grant && !snoop_valid;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:   if (accept && !hit) state_d = victim_dirty ? C_WRBACK : C_BUSREQ;
            C_WRBACK: if (wb_done)        state_d = C_BUSREQ;
            C_BUSREQ: if (bus_done)       state_d = C_IDLE;
            default:                      state_d = C_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= C_IDLE;
            addr_q   <= '0;
            write_q  <= 1'b0;
            victim_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q   <= cpu_req_addr;
                write_q  <= cpu_req_write;
                victim_q <= look_tag;
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_ready     = (state_q == C_IDLE) && !snoop_valid;
        bus_req_valid = (state_q == C_BUSREQ);
        bus_req_op    = write_q ? OP_WRMISS : OP_RDMISS;
        bus_req_addr  = addr_q;
        wb_req_valid  = (state_q == C_WRBACK);
        wb_req_addr   = {victim_q, addr_q[IDX_W-1:0]};
        wr_en         = wb_done || bus_done;
        wr_idx        = addr_q[IDX_W-1:0];
        wr_tag        = wb_done ? victim_q : addr_q[ADDR_W-1:IDX_W];
        wr_state      = wb_done ? LINE_I : (write_q ? LINE_E : LINE_S);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_done <= 1'b0;
            cpu_hit  <= 1'b0;
        end else begin
            cpu_done <= (accept && hit) || bus_done;
            cpu_hit  <= accept && hit;
        end
    end

    // R10: a pending miss request stays put until granted
    a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && (!bus_grant || snoop_valid)
        |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_op));

    // R10: a pending write-back stays put until acknowledged
    a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_valid && (!wb_ack || snoop_valid)
        |=> wb_req_valid && $stable(wb_req_addr));

    // R5: no refill request while a victim write-back is still unacknowledged
    a_r5_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_valid && !wb_ack |=> !bus_req_valid);

    // R9: a snoop cycle never completes a processor access
    a_r9_snoop_stall: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |=> !cpu_done);

    // R3: a hit completes with nothing outstanding on the bus
    a_r3_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_hit |-> !bus_req_valid && !wb_req_valid);

endmodule

// File: rtl/msi_coherence_ctrl.sv
module msi_coherence_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    output logic              wb_req_valid,
    output logic [ADDR_W-1:0] wb_req_addr,
    input  logic              wb_ack,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_op,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              supply_valid,
    output logic [ADDR_W-1:0] supply_addr
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] look_tag, snp_tag, cpu_wr_tag;
    line_state_e      look_state, snp_state, snp_wr_state, cpu_wr_state;
    logic             snp_we, cpu_we;
    logic [IDX_W-1:0] cpu_wr_idx;
    bus_op_e          req_op;

    assign bus_req_op = req_op;

    msi_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_idx      (cpu_req_addr[IDX_W-1:0]),
        .cpu_tag_o    (look_tag),
        .cpu_state_o  (look_state),
        .snp_idx      (snoop_addr[IDX_W-1:0]),
        .snp_tag_o    (snp_tag),
        .snp_state_o  (snp_state),
        .snp_we       (snp_we),
        .snp_state_i  (snp_wr_state),
        .cpu_we       (cpu_we),
        .cpu_wr_idx   (cpu_wr_idx),
        .cpu_wr_tag   (cpu_wr_tag),
        .cpu_wr_state (cpu_wr_state)
    );

    msi_snoop_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_snoop (
        .clk          (clk),
        .rst_n        (rst_n),
        .snoop_valid  (snoop_valid),
        .snoop_op     (bus_op_e'(snoop_op)),
        .snoop_addr   (snoop_addr),
        .line_tag     (snp_tag),
        .line_state   (snp_state),
        .wr_en        (snp_we),
        .wr_state     (snp_wr_state),
        .supply_valid (supply_valid),
        .supply_addr  (supply_addr)
    );

    msi_cpu_fsm #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .snoop_valid   (snoop_valid),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .look_tag      (look_tag),
        .look_state    (look_state),
        .bus_grant     (bus_grant),
        .wb_ack        (wb_ack),
        .cpu_ready     (cpu_ready),
        .cpu_done      (cpu_done),
        .cpu_hit       (cpu_hit),
        .bus_req_valid (bus_req_valid),
        .bus_req_op    (req_op),
        .bus_req_addr  (bus_req_addr),
        .wb_req_valid  (wb_req_valid),
        .wb_req_addr   (wb_req_addr),
        .wr_en         (cpu_we),
        .wr_idx        (cpu_wr_idx),
        .wr_tag        (cpu_wr_tag),
        .wr_state      (cpu_wr_state)
    );

    // R10: never a miss request and a write-back at once
    a_r10_exclusive_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req_valid, wb_req_valid}));

endmodule

// File: tb/msi_coherence_ctrl_test.sv
module msi_coherence_ctrl_test;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic              cpu_ready, cpu_done, cpu_hit;
    logic              bus_req_valid;
    logic [1:0]        bus_req_op;
    logic [ADDR_W-1:0] bus_req_addr;
    logic              bus_grant = 1'b0;
    logic              wb_req_valid;
    logic [ADDR_W-1:0] wb_req_addr;
    logic              wb_ack = 1'b0;
    logic              snoop_valid = 1'b0;
    logic [1:0]        snoop_op = 2'd0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              supply_valid;
    logic [ADDR_W-1:0] supply_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // index = low 4 bits, tag = upper bits
    localparam logic [ADDR_W-1:0] A = 12'h011;
    localparam logic [ADDR_W-1:0] C = 12'h021;
    localparam logic [ADDR_W-1:0] M = 12'h051;
    localparam logic [ADDR_W-1:0] B = 12'h035;
    localparam logic [ADDR_W-1:0] D = 12'h0A7;

    always #2.5 clk = ~clk;

    msi_coherence_ctrl #(.NUM_LINES(16), .ADDR_W(ADDR_W)) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One processor access; a miss is granted and checked
    task automatic access(input bit wr, input logic [ADDR_W-1:0] addr,
                          input bit exp_hit, input string req);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr;
        @(posedge clk); @(negedge clk);
        cpu_req_valid = 1'b0;
        if (exp_hit) begin
            chk({req, " hit done"}, int'(cpu_done), 1);
            chk({req, " hit flag"}, int'(cpu_hit), 1);
            chk({req, " no bus req"}, int'(bus_req_valid), 0);
        end else begin
            chk({req, " bus req"}, int'(bus_req_valid), 1);
            chk({req, " bus op"}, int'(bus_req_op), wr ? 2 : 1);
            chk({req, " bus addr"}, int'(bus_req_addr), int'(addr));
            bus_grant = 1'b1;
            @(posedge clk); @(negedge clk);
            bus_grant = 1'b0;
            chk({req, " miss done"}, int'(cpu_done), 1);
            chk({req, " miss flag"}, int'(cpu_hit), 0);
        end
    endtask

    task automatic snoop(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                         input bit exp_sup, input string req);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_op = op; snoop_addr = addr;
        #1;
        chk("R9 ready low during snoop", int'(cpu_ready), 0);
        @(posedge clk); @(negedge clk);
        snoop_valid = 1'b0; snoop_op = 2'd0;
        chk({req, " supply"}, int'(supply_valid), int'(exp_sup));
        if (exp_sup) chk({req, " supply addr"}, int'(supply_addr), int'(addr));
    endtask

    task automatic t_reset();
        chk("R1 ready", int'(cpu_ready), 1);
        chk("R1 bus idle", int'(bus_req_valid), 0);
        chk("R1 wb idle", int'(wb_req_valid), 0);
        chk("R1 supply idle", int'(supply_valid), 0);
        chk("R1 done low", int'(cpu_done), 0);
        access(1'b0, D, 1'b0, "R1 invalid after reset");
    endtask

    task automatic t_read_miss_hit();
        access(1'b0, A, 1'b0, "R2 read miss");
        access(1'b0, A, 1'b1, "R3 read hit S");
    endtask

    task automatic t_write_shared();
        access(1'b1, A, 1'b0, "R4 write to S");
        access(1'b1, A, 1'b1, "R3 write hit E");
        access(1'b0, A, 1'b1, "R3 read hit E");
    endtask

    task automatic t_snoop_read_dirty();
        snoop(2'd1, A, 1'b1, "R6 snoop rd miss on E");
        access(1'b0, A, 1'b1, "R6 line now S read");
        access(1'b1, A, 1'b0, "R6 line now S write");
    endtask

    task automatic t_snoop_mismatch();
        snoop(2'd2, M, 1'b0, "R8 tag mismatch");
        access(1'b1, A, 1'b1, "R8 line still E");
        snoop(2'd3, 12'h0FC, 1'b0, "R8 invalid line");
    endtask

    task automatic t_evict();
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = C;
        @(posedge clk); @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R5 wb first", int'(wb_req_valid), 1);
        chk("R5 wb addr victim", int'(wb_req_addr), int'(A));
        chk("R5 no bus before ack", int'(bus_req_valid), 0);
        @(posedge clk); @(negedge clk);
        chk("R10 wb held", int'(wb_req_valid), 1);
        chk("R10 wb addr held", int'(wb_req_addr), int'(A));
        wb_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        wb_ack = 1'b0;
        chk("R5 wb dropped", int'(wb_req_valid), 0);
        chk("R5 bus after ack", int'(bus_req_valid), 1);
        chk("R5 bus op", int'(bus_req_op), 1);
        chk("R5 bus addr", int'(bus_req_addr), int'(C));
        bus_grant = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_grant = 1'b0;
        chk("R5 refill done", int'(cpu_done), 1);
        snoop(2'd1, A, 1'b0, "R5 victim gone");
        access(1'b0, C, 1'b1, "R2 refilled line S");
    endtask

    task automatic t_snoop_invalidate();
        access(1'b1, B, 1'b0, "R4 write miss from I");
        snoop(2'd2, B, 1'b1, "R7 snoop wr miss on E");
        access(1'b0, B, 1'b0, "R7 line invalid after wr miss");
        snoop(2'd3, B, 1'b0, "R7 invalidate on S");
        access(1'b0, B, 1'b0, "R7 line invalid after invalidate");
    endtask

    task automatic t_priority();
        @(negedge clk);
        snoop_valid = 1'b1; snoop_op = 2'd0; snoop_addr = 12'h0FF;
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = C;
        #1;
        chk("R9 ready low with snoop", int'(cpu_ready), 0);
        @(posedge clk); @(negedge clk);
        snoop_valid = 1'b0;
        chk("R9 no done while snooped", int'(cpu_done), 0);
        @(posedge clk); @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R9 accepted after snoop", int'(cpu_done), 1);
        // grant during a snoop cycle is ignored
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_addr = 12'h0B7;
        @(posedge clk); @(negedge clk);
        cpu_req_valid = 1'b0;
        bus_grant = 1'b1; snoop_valid = 1'b1; snoop_addr = 12'h000;
        @(posedge clk); @(negedge clk);
        bus_grant = 1'b0; snoop_valid = 1'b0;
        chk("R9 grant ignored req held", int'(bus_req_valid), 1);
        chk("R9 grant ignored no done", int'(cpu_done), 0);
        bus_grant = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_grant = 1'b0;
        chk("R9 grant taken later", int'(cpu_done), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_write_shared();
        t_snoop_read_dirty();
        t_snoop_mismatch();
        t_evict();
        t_snoop_invalidate();
        t_priority();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule